// File: doc/BRIEF.md
# Per-Cycle Execution Trace Recorder

This block sits beside a processor core and keeps a rolling history of what the core did, one entry for every execution cycle the core marks with a strobe. Each entry holds six fields: the 16-bit opcode word, the 23-bit program address, the byte written back to the register file, a 23-bit data-memory address, the data byte moved, and an 8-bit mask of the status flags touched in that cycle. Each field has its own valid bit, and a field that means nothing for the cycle is stored as zero with its valid bit clear. For example, a register-only arithmetic cycle leaves both data-memory fields invalid.

An instruction that takes several cycles leaves several entries. A two-cycle word add, for instance, leaves a first entry with its own address and the low result byte. The entry after it holds the following instruction's address and the high result byte. The history is a power-of-two circular store. Once it has filled, new entries overwrite the oldest ones, and a sticky flag reports that this has happened.

A debug host stops capture by raising the freeze input, which keeps every stored entry. It then reads entries by index, where index 0 is the oldest surviving entry. Each read returns a registered result one clock later.

Top module: `trace_recorder`

## Requirements
- R1: While reset is low and directly after it, the stored-entry count is 0, the wrap flag is 0, the read-hit output is 0, and every read field and valid bit is 0.
- R2: Each rising clock edge with obs_valid high, cap_en high and freeze low stores exactly one entry. Entries are kept in arrival order, so back-to-back strobes (such as the two cycles of a word operation) give adjacent indices.
- R3: An edge with obs_valid low or cap_en low stores nothing, and the count and stored entries stay unchanged.
- R4: While freeze is high, no entry is stored even if obs_valid and cap_en are high, and all stored entries are kept.
- R5: The bits of obs_fld_vld and rd_fld_vld map as follows: bit 0 opcode, bit 1 program address, bit 2 register byte, bit 3 data address, bit 4 data byte, bit 5 flag mask. A field stored with its bit clear reads back as zero with that bit clear. A field stored with its bit set reads back unchanged.
- R6: The store holds the most recent DEPTH entries. Each write beyond that overwrites the oldest one.
- R7: rec_count equals the smaller of the number of entries written since reset and DEPTH. The wrap flag rises on the DEPTH-th write since reset and stays high until reset.
- R8: Read index 0 names the oldest surviving entry and index rec_count-1 the newest. The read outputs after a rising edge show the entry chosen by rd_idx at that edge.
- R9: rd_hit, the read fields and the read valid bits are all zero after any edge at which freeze was low or rd_idx was not below rec_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | Core marks one executed cycle |
| cap_en | input | 1 | Capture enable |
| freeze | input | 1 | Stop capture and allow readout |
| obs_insn | input | 16 | Opcode word of the cycle |
| obs_pc | input | 23 | Program address of the cycle |
| obs_rval | input | 8 | Register write-back byte |
| obs_daddr | input | 23 | Data-memory address |
| obs_dval | input | 8 | Data byte |
| obs_flags | input | 8 | Mask of status flags updated |
| obs_fld_vld | input | 6 | Per-field valid bits (mapping in R5) |
| rd_idx | input | IDX_W (4) | Read index, 0 is the oldest entry |
| rd_hit | output | 1 | Read result is a stored entry |
| rd_insn | output | 16 | Read opcode word |
| rd_pc | output | 23 | Read program address |
| rd_rval | output | 8 | Read register byte |
| rd_daddr | output | 23 | Read data address |
| rd_dval | output | 8 | Read data byte |
| rd_flags | output | 8 | Read flag mask |
| rd_fld_vld | output | 6 | Read per-field valid bits |
| wrapped | output | 1 | Sticky: the store has overwritten entries |
| rec_count | output | IDX_W+1 (5) | Number of readable entries |

## Verification
A write pointer that skips a step, or one that moves on a frozen or idle cycle, shows at rec_count at the very next edge. After a wrap, the same fault shows at the next frozen read as entries that are shifted or missing. If the oldest-entry offset is computed wrongly, a frozen read returns a neighbouring entry one clock after the index is applied. A masking fault shows as a nonzero field next to a clear valid bit on that same read. A stuck or early wrap flag differs from the write count at the edge of the DEPTH-th write.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int INSN_W = 16;
  localparam int PA_W   = 23;
  localparam int RV_W   = 8;
  localparam int DA_W   = 23;
  localparam int DV_W   = 8;
  localparam int FL_W   = 8;
  localparam int NFLD   = 6;

  localparam int F_INSN = 0;
  localparam int F_PC   = 1;
  localparam int F_RV   = 2;
  localparam int F_DA   = 3;
  localparam int F_DV   = 4;
  localparam int F_FL   = 5;

  typedef struct packed {
    logic [NFLD-1:0]   vld;
    logic [FL_W-1:0]   flags;
    logic [DV_W-1:0]   dval;
    logic [DA_W-1:0]   daddr;
    logic [RV_W-1:0]   rval;
    logic [PA_W-1:0]   pc;
    logic [INSN_W-1:0] insn;
  } trc_rec_t;

  // Zero every field whose valid bit is clear.
  function automatic trc_rec_t trc_scrub(input trc_rec_t r);
    trc_rec_t o;
    o       = r;
    o.insn  = r.vld[F_INSN] ? r.insn  : '0;
    o.pc    = r.vld[F_PC]   ? r.pc    : '0;
    o.rval  = r.vld[F_RV]   ? r.rval  : '0;
    o.daddr = r.vld[F_DA]   ? r.daddr : '0;
    o.dval  = r.vld[F_DV]   ? r.dval  : '0;
    o.flags = r.vld[F_FL]   ? r.flags : '0;
    return o;
  endfunction

endpackage

// File: rtl/trc_wr_ctrl.sv
module trc_wr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  output logic [IDX_W-1:0] wptr,
  output logic             wrapped,
  output logic [IDX_W:0]   count
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic roll;
  assign roll = wr_en && (wptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      wrapped <= 1'b0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (roll)  wrapped <= 1'b1;
    end
  end

  assign count = wrapped ? (IDX_W+1)'(DEPTH) : {1'b0, wptr};

  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wptr == IDX_W'($past(wptr) + 1'b1)));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wptr));

  a_r7_roll_sets_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> wrapped);

  a_r7_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);

endmodule

// File: rtl/trc_store.sv
module trc_store #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  trc_pkg::trc_rec_t wdata,
  input  logic [IDX_W-1:0]  raddr,
  output trc_pkg::trc_rec_t rdata
);

  trc_pkg::trc_rec_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/trc_rd_port.sv
module trc_rd_port #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  wptr,
  input  logic              wrapped,
  input  logic [IDX_W:0]    count,
  output logic [IDX_W-1:0]  raddr,
  input  trc_pkg::trc_rec_t rdata,
  output logic              rd_ok,
  output trc_pkg::trc_rec_t rd_rec
);

  // Oldest surviving entry sits at the write pointer once the store has wrapped.
  function automatic logic [IDX_W-1:0] slot_of(input logic [IDX_W-1:0] base,
                                               input logic [IDX_W-1:0] off,
                                               input logic             wr);
    return wr ? IDX_W'(base + off) : off;
  endfunction

  logic hit;
  assign raddr = slot_of(wptr, idx, wrapped);
  assign hit   = freeze && ({1'b0, idx} < count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ok  <= 1'b0;
      rd_rec <= '0;
    end else begin
      rd_ok  <= hit;
      rd_rec <= hit ? rdata : '0;
    end
  end

  a_r9_live_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> !rd_ok);

  a_r9_range_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx} >= count) |=> (!rd_ok && rd_rec == '0));

endmodule

// File: rtl/trace_recorder.sv
module trace_recorder #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         obs_valid,
  input  logic                         cap_en,
  input  logic                         freeze,
  input  logic [trc_pkg::INSN_W-1:0]   obs_insn,
  input  logic [trc_pkg::PA_W-1:0]     obs_pc,
  input  logic [trc_pkg::RV_W-1:0]     obs_rval,
  input  logic [trc_pkg::DA_W-1:0]     obs_daddr,
  input  logic [trc_pkg::DV_W-1:0]     obs_dval,
  input  logic [trc_pkg::FL_W-1:0]     obs_flags,
  input  logic [trc_pkg::NFLD-1:0]     obs_fld_vld,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic                         rd_hit,
  output logic [trc_pkg::INSN_W-1:0]   rd_insn,
  output logic [trc_pkg::PA_W-1:0]     rd_pc,
  output logic [trc_pkg::RV_W-1:0]     rd_rval,
  output logic [trc_pkg::DA_W-1:0]     rd_daddr,
  output logic [trc_pkg::DV_W-1:0]     rd_dval,
  output logic [trc_pkg::FL_W-1:0]     rd_flags,
  output logic [trc_pkg::NFLD-1:0]     rd_fld_vld,
  output logic                         wrapped,
  output logic [IDX_W:0]               rec_count
);

  import trc_pkg::*;

  logic             wr_en;
  logic [IDX_W-1:0] wptr;
  logic [IDX_W-1:0] raddr;
  trc_rec_t         obs_rec;
  trc_rec_t         wr_rec;
  trc_rec_t         st_rec;
  trc_rec_t         out_rec;

  assign wr_en = obs_valid && cap_en && !freeze;

  always_comb begin
    obs_rec.vld   = obs_fld_vld;
    obs_rec.insn  = obs_insn;
    obs_rec.pc    = obs_pc;
    obs_rec.rval  = obs_rval;
    obs_rec.daddr = obs_daddr;
    obs_rec.dval  = obs_dval;
    obs_rec.flags = obs_flags;
  end

  assign wr_rec = trc_scrub(obs_rec);

  trc_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wptr    (wptr),
    .wrapped (wrapped),
    .count   (rec_count)
  );

  trc_store #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wptr),
    .wdata (wr_rec),
    .raddr (raddr),
    .rdata (st_rec)
  );

  trc_rd_port #(.DEPTH(DEPTH)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (freeze),
    .idx     (rd_idx),
    .wptr    (wptr),
    .wrapped (wrapped),
    .count   (rec_count),
    .raddr   (raddr),
    .rdata   (st_rec),
    .rd_ok   (rd_hit),
    .rd_rec  (out_rec)
  );

  assign rd_insn    = out_rec.insn;
  assign rd_pc      = out_rec.pc;
  assign rd_rval    = out_rec.rval;
  assign rd_daddr   = out_rec.daddr;
  assign rd_dval    = out_rec.dval;
  assign rd_flags   = out_rec.flags;
  assign rd_fld_vld = out_rec.vld;

  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(rec_count) && $stable(wptr)));

  a_r5_daddr_scrubbed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !rd_fld_vld[F_DA]) |-> (rd_daddr == '0));

  a_r5_rval_scrubbed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !rd_fld_vld[F_RV]) |-> (rd_rval == '0));

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (rec_count == '0 && !wrapped && !rd_hit));

endmodule

// File: tb/trace_recorder_tb.sv
module trace_recorder_tb;

  localparam int DEPTH = 16;
  localparam int IW    = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          obs_valid = 1'b0, cap_en = 1'b0, freeze = 1'b0;
  logic [15:0]   obs_insn = '0;
  logic [22:0]   obs_pc = '0, obs_daddr = '0;
  logic [7:0]    obs_rval = '0, obs_dval = '0, obs_flags = '0;
  logic [5:0]    obs_fld_vld = '0;
  logic [IW-1:0] rd_idx = '0;

  logic          rd_hit, wrapped;
  logic [15:0]   rd_insn;
  logic [22:0]   rd_pc, rd_daddr;
  logic [7:0]    rd_rval, rd_dval, rd_flags;
  logic [5:0]    rd_fld_vld;
  logic [IW:0]   rec_count;

  trace_recorder #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .cap_en(cap_en),
    .freeze(freeze), .obs_insn(obs_insn), .obs_pc(obs_pc),
    .obs_rval(obs_rval), .obs_daddr(obs_daddr), .obs_dval(obs_dval),
    .obs_flags(obs_flags), .obs_fld_vld(obs_fld_vld), .rd_idx(rd_idx),
    .rd_hit(rd_hit), .rd_insn(rd_insn), .rd_pc(rd_pc), .rd_rval(rd_rval),
    .rd_daddr(rd_daddr), .rd_dval(rd_dval), .rd_flags(rd_flags),
    .rd_fld_vld(rd_fld_vld), .wrapped(wrapped), .rec_count(rec_count)
  );

  typedef struct {
    logic [15:0] insn;
    logic [22:0] pc;
    logic [7:0]  rv;
    logic [22:0] da;
    logic [7:0]  dv;
    logic [7:0]  fl;
    logic [5:0]  v;
  } ent_t;

  ent_t hist[$];
  int   n_written = 0;
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic ent_t blank();
    ent_t e;
    e.insn = '0; e.pc = '0; e.rv = '0; e.da = '0; e.dv = '0; e.fl = '0; e.v = '0;
    return e;
  endfunction

  task automatic compare(input bit e_ok, input ent_t e);
    chk("R9 rd_hit", 32'(rd_hit), 32'(e_ok));
    chk("R8/R5 opcode", 32'(rd_insn), 32'(e.insn));
    chk("R8/R5 program address", 32'(rd_pc), 32'(e.pc));
    chk("R8/R5 register byte", 32'(rd_rval), 32'(e.rv));
    chk("R8/R5 data address", 32'(rd_daddr), 32'(e.da));
    chk("R8/R5 data byte", 32'(rd_dval), 32'(e.dv));
    chk("R8/R5 flag mask", 32'(rd_flags), 32'(e.fl));
    chk("R5 valid bits", 32'(rd_fld_vld), 32'(e.v));
    chk("R7 wrapped", 32'(wrapped), 32'(n_written >= DEPTH));
    chk("R6/R7 rec_count", 32'(rec_count), 32'(hist.size()));
  endtask

  // Called at a falling edge: drive, predict, clock, compare.
  task automatic step(input bit v, input bit en, input bit fz, input int idx,
                      input logic [5:0] m);
    ent_t e_rd;
    ent_t w;
    bit   e_ok;
    obs_valid = v; cap_en = en; freeze = fz; rd_idx = IW'(idx);
    obs_insn = 16'($urandom); obs_pc = 23'($urandom); obs_rval = 8'($urandom);
    obs_daddr = 23'($urandom); obs_dval = 8'($urandom); obs_flags = 8'($urandom);
    obs_fld_vld = m;
    e_ok = fz && (idx < hist.size());
    e_rd = e_ok ? hist[idx] : blank();
    if (v && en && !fz) begin
      w.v    = m;
      w.insn = m[0] ? obs_insn  : '0;
      w.pc   = m[1] ? obs_pc    : '0;
      w.rv   = m[2] ? obs_rval  : '0;
      w.da   = m[3] ? obs_daddr : '0;
      w.dv   = m[4] ? obs_dval  : '0;
      w.fl   = m[5] ? obs_flags : '0;
      hist.push_back(w);
      if (hist.size() > DEPTH) void'(hist.pop_front());
      n_written++;
    end
    @(posedge clk);
    @(negedge clk);
    compare(e_ok, e_rd);
  endtask

  task automatic read_all(input int upto);
    for (int i = 0; i < upto; i++) step(1'b1, 1'b1, 1'b1, i, 6'h3F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compare(1'b0, blank());
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 0, 6'h00);

    // R2/R5: captures with assorted field masks; arithmetic cycles lack data fields
    step(1'b1, 1'b1, 1'b0, 0, 6'h3F);
    step(1'b1, 1'b1, 1'b0, 0, 6'h27);
    // R2: two-cycle word operation, back-to-back strobes
    step(1'b1, 1'b1, 1'b0, 0, 6'h27);
    step(1'b1, 1'b1, 1'b0, 0, 6'h06);
    step(1'b1, 1'b1, 1'b0, 0, 6'h1B);
    // R3: enable low, then strobe low
    step(1'b1, 1'b0, 1'b0, 0, 6'h3F);
    step(1'b0, 1'b1, 1'b0, 0, 6'h3F);
    // R9: index applied while live
    step(1'b0, 1'b1, 1'b0, 1, 6'h3F);
    // R4/R8/R9: frozen with strobe high, read past the end
    read_all(8);
    // R2: capture resumes after freeze drops
    step(1'b1, 1'b1, 1'b0, 0, 6'h00);
    step(1'b1, 1'b1, 1'b0, 0, 6'h3F);
    read_all(9);

    // R6/R7: overflow the store
    for (int i = 0; i < 20; i++)
      step(1'b1, (i % 7) != 3, 1'b0, 0, 6'($urandom));
    read_all(DEPTH);
    for (int i = 0; i < DEPTH + 3; i++)
      step(1'b1, 1'b1, 1'b0, 0, 6'($urandom));
    read_all(DEPTH);
    step(1'b1, 1'b1, 1'b1, DEPTH - 1, 6'h3F);

    // R1: reset again clears count and wrap
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    hist.delete();
    n_written = 0;
    compare(1'b0, blank());
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b0, 0, 6'h3F);
    read_all(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule